// File: doc/BRIEF.md
# Prefix Swapper with Frame Reference and Change Tracking

This block sits between a processor's address generation and main storage. It turns a real address into an absolute address by exchanging two 8 KB windows: the window at address zero and the window that starts at the per-processor prefix value. Every other address passes unchanged. The translation is purely combinational, so the absolute address is ready in the same cycle as the real address.

Each access that lands inside installed storage also marks the 4 KB frame it touched in a small internal key array: a read sets the frame's reference bit and a write sets its change bit. The bits are sticky and only reset clears them. The marking is registered: the array and a one-cycle update strobe change on the clock edge that samples the access. A combinational read port lets the surrounding logic inspect any frame's two bits.

Top module: `skey_pfx_unit`

## Requirements
- R1: A real address whose bits above bit 12 are all zero maps to that address plus the prefix value.
- R2: Otherwise, a real address whose bits above bit 12 equal the prefix's bits above bit 12 maps to that address minus the prefix value, giving an absolute address below 0x2000.
- R3: Every other real address maps to itself; with a prefix of zero the low window maps to itself.
- R4: A prefix write stores the written value with bits 12 to 0 cleared and is used for translation from the following cycle.
- R5: A frame is marked only when the absolute address is less than or equal to `mem_limit` and its frame number (absolute address shifted right by 12) is below the key array depth (64 by default); otherwise no update strobe appears.
- R6: One cycle after a marked access, `upd_valid` is 1, `upd_frame` carries the frame number, `upd_ref` equals the access's read flag and `upd_chg` its write flag; an access with neither flag set marks nothing.
- R7: After reset every frame's reference and change bits are zero and `upd_valid` is 0; once set, a bit stays set until reset.
- R8: `key_rd_ref` and `key_rd_chg` show the current reference and change bits of frame `key_rd_idx`, including updates made on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pfx_we | input | 1 | Prefix write strobe |
| pfx_wdata | input | 32 | Prefix value to store (low 13 bits ignored) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_real_addr | input | 32 | Real address of the access |
| acc_rd | input | 1 | Access is permitted to read |
| acc_wr | input | 1 | Access is permitted to write |
| mem_limit | input | 32 | Highest absolute address that counts as installed storage |
| key_rd_idx | input | 6 | Frame whose key bits are shown |
| abs_addr | output | 32 | Absolute address (combinational) |
| upd_valid | output | 1 | A frame was marked on the last edge |
| upd_frame | output | 6 | Frame marked on the last edge |
| upd_ref | output | 1 | Reference bit was set by that update |
| upd_chg | output | 1 | Change bit was set by that update |
| key_rd_ref | output | 1 | Reference bit of frame key_rd_idx |
| key_rd_chg | output | 1 | Change bit of frame key_rd_idx |

## Verification
The awkward corner is a prefix near the top of the address space, where the swapped window's upper end wraps and a low-window access maps to an absolute address that is inside the memory limit yet beyond the key array. The stimulus reaches it by writing a prefix of 0xFFFFE000 with the limit opened to all ones, then accessing both the top window (which must land in frame 1) and the low window (which must produce no update). The exact-limit boundary, a frame revisited with read and write in turn, and an access with no permission flags are driven as separate steps, and each frame's bits are read back through the key port.

// File: rtl/skey_pfx_pkg.sv
package skey_pfx_pkg;

    // Bits of the window that is exchanged with the prefix area (8 KB)
    localparam int unsigned SWAP_BITS  = 13;
    // Bits of one storage frame (4 KB)
    localparam int unsigned FRAME_BITS = 12;

    typedef struct packed {
        logic ref_bit;
        logic chg_bit;
    } skey_t;

endpackage

// File: rtl/pfx_reg.sv
module pfx_reg
    import skey_pfx_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] prefix
);

    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << SWAP_BITS) - AW'(1));

    logic [AW-1:0] prefix_d, prefix_q;

    always_comb begin
        prefix_d = prefix_q;
        if (we) begin
            prefix_d = wdata & ALIGN_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prefix_q <= '0;
        else        prefix_q <= prefix_d;
    end

    assign prefix = prefix_q;

endmodule

// File: rtl/pfx_addr_map.sv
module pfx_addr_map
    import skey_pfx_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] real_addr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] abs_addr
);

    localparam int unsigned HI_W = AW - SWAP_BITS;

    logic [HI_W-1:0] real_hi, pfx_hi;
    logic            in_low_win, in_pfx_win;

    always_comb begin
        real_hi    = real_addr[AW-1:SWAP_BITS];
        pfx_hi     = prefix[AW-1:SWAP_BITS];
        in_low_win = (real_hi == '0);
        in_pfx_win = (real_hi == pfx_hi);
        // low window takes priority, so a zero prefix maps to identity
        if (in_low_win)      abs_addr = real_addr + prefix;
        else if (in_pfx_win) abs_addr = real_addr - prefix;
        else                 abs_addr = real_addr;
    end

endmodule

// File: rtl/skey_array.sv
module skey_array
    import skey_pfx_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned FRAMES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic [AW-1:0]             abs_addr,
    input  logic [AW-1:0]             mem_limit,
    input  logic                      acc_rd,
    input  logic                      acc_wr,
    input  logic [$clog2(FRAMES)-1:0] rd_idx,
    output logic                      upd_valid,
    output logic [$clog2(FRAMES)-1:0] upd_frame,
    output logic                      upd_ref,
    output logic                      upd_chg,
    output logic                      rd_ref,
    output logic                      rd_chg
);

    localparam int unsigned IDX_W = $clog2(FRAMES);
    localparam int unsigned FN_W  = AW - FRAME_BITS;

    typedef struct packed {
        skey_t [FRAMES-1:0] keys;
        logic               upd_valid;
        logic [IDX_W-1:0]   upd_frame;
        logic               upd_ref;
        logic               upd_chg;
    } state_t;

    state_t          st_d, st_q;
    logic [FN_W-1:0] frame_full;
    logic [IDX_W-1:0] frame_idx;
    logic            in_storage, in_array, do_mark;

    always_comb begin
        frame_full = abs_addr[AW-1:FRAME_BITS];
        frame_idx  = frame_full[IDX_W-1:0];
        in_storage = (abs_addr <= mem_limit);
        in_array   = (frame_full < FN_W'(FRAMES));
        do_mark    = acc_valid && in_storage && in_array && (acc_rd || acc_wr);

        st_d           = st_q;
        st_d.upd_valid = 1'b0;
        st_d.upd_frame = '0;
        st_d.upd_ref   = 1'b0;
        st_d.upd_chg   = 1'b0;
        if (do_mark) begin
            st_d.keys[frame_idx].ref_bit = st_q.keys[frame_idx].ref_bit | acc_rd;
            st_d.keys[frame_idx].chg_bit = st_q.keys[frame_idx].chg_bit | acc_wr;
            st_d.upd_valid = 1'b1;
            st_d.upd_frame = frame_idx;
            st_d.upd_ref   = acc_rd;
            st_d.upd_chg   = acc_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upd_valid = st_q.upd_valid;
    assign upd_frame = st_q.upd_frame;
    assign upd_ref   = st_q.upd_ref;
    assign upd_chg   = st_q.upd_chg;
    assign rd_ref    = st_q.keys[rd_idx].ref_bit;
    assign rd_chg    = st_q.keys[rd_idx].chg_bit;

    // R6
    chg_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upd_valid && st_q.upd_chg) |-> st_q.keys[st_q.upd_frame].chg_bit);

    // R6
    ref_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upd_valid && st_q.upd_ref) |-> st_q.keys[st_q.upd_frame].ref_bit);

    generate
        for (genvar g = 0; g < FRAMES; g++) begin : g_sticky
            // R7
            ref_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.keys[g].ref_bit |=> st_q.keys[g].ref_bit);
            // R7
            chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.keys[g].chg_bit |=> st_q.keys[g].chg_bit);
        end
    endgenerate

endmodule

// File: rtl/skey_pfx_unit.sv
module skey_pfx_unit
    import skey_pfx_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned FRAMES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pfx_we,
    input  logic [AW-1:0]             pfx_wdata,
    input  logic                      acc_valid,
    input  logic [AW-1:0]             acc_real_addr,
    input  logic                      acc_rd,
    input  logic                      acc_wr,
    input  logic [AW-1:0]             mem_limit,
    input  logic [$clog2(FRAMES)-1:0] key_rd_idx,
    output logic [AW-1:0]             abs_addr,
    output logic                      upd_valid,
    output logic [$clog2(FRAMES)-1:0] upd_frame,
    output logic                      upd_ref,
    output logic                      upd_chg,
    output logic                      key_rd_ref,
    output logic                      key_rd_chg
);

    logic [AW-1:0] prefix_q;

    pfx_reg #(.AW(AW)) i_pfx_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (pfx_we),
        .wdata  (pfx_wdata),
        .prefix (prefix_q)
    );

    pfx_addr_map #(.AW(AW)) i_pfx_addr_map (
        .real_addr (acc_real_addr),
        .prefix    (prefix_q),
        .abs_addr  (abs_addr)
    );

    skey_array #(.AW(AW), .FRAMES(FRAMES)) i_skey_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .abs_addr  (abs_addr),
        .mem_limit (mem_limit),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .rd_idx    (key_rd_idx),
        .upd_valid (upd_valid),
        .upd_frame (upd_frame),
        .upd_ref   (upd_ref),
        .upd_chg   (upd_chg),
        .rd_ref    (key_rd_ref),
        .rd_chg    (key_rd_chg)
    );

    // R3
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abs_addr[SWAP_BITS-1:0] == acc_real_addr[SWAP_BITS-1:0]);

    // R1
    low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_real_addr[AW-1:SWAP_BITS] == '0) |->
        (abs_addr[AW-1:SWAP_BITS] == prefix_q[AW-1:SWAP_BITS]));

    // R2
    pfx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_real_addr[AW-1:SWAP_BITS] != '0) &&
         (acc_real_addr[AW-1:SWAP_BITS] == prefix_q[AW-1:SWAP_BITS])) |->
        (abs_addr[AW-1:SWAP_BITS] == '0));

    // R4
    pfx_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_we |=> (prefix_q[SWAP_BITS-1:0] == '0) &&
                   (prefix_q[AW-1:SWAP_BITS] == $past(pfx_wdata[AW-1:SWAP_BITS])));

    // R5
    beyond_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (abs_addr > mem_limit)) |=> !upd_valid);

    // R6
    no_flag_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr) |=> !upd_valid);

endmodule

// File: tb/test_skey_pfx_unit.sv
module test_skey_pfx_unit;

    localparam int AW     = 32;
    localparam int FRAMES = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            pfx_we;
    logic [AW-1:0]   pfx_wdata;
    logic            acc_valid;
    logic [AW-1:0]   acc_real_addr;
    logic            acc_rd, acc_wr;
    logic [AW-1:0]   mem_limit;
    logic [5:0]      key_rd_idx;
    logic [AW-1:0]   abs_addr;
    logic            upd_valid, upd_ref, upd_chg, key_rd_ref, key_rd_chg;
    logic [5:0]      upd_frame;

    always #5 clk = ~clk;

    skey_pfx_unit i_skey_pfx_unit (
        .clk(clk), .rst_n(rst_n), .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
        .acc_valid(acc_valid), .acc_real_addr(acc_real_addr),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .mem_limit(mem_limit),
        .key_rd_idx(key_rd_idx), .abs_addr(abs_addr), .upd_valid(upd_valid),
        .upd_frame(upd_frame), .upd_ref(upd_ref), .upd_chg(upd_chg),
        .key_rd_ref(key_rd_ref), .key_rd_chg(key_rd_chg)
    );

    typedef struct {
        bit         vld;
        logic [5:0] frame;
        bit         r;
        bit         c;
        string      req;
    } exp_t;

    exp_t          sbq[$];
    logic [1:0]    model [FRAMES];   // [1] reference, [0] change
    logic [AW-1:0] pfx_m;
    logic [AW-1:0] limit_m;
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            mon_on = 0;
    bit            ended  = 0;

    assign mem_limit = limit_m;

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] map_ref(input logic [AW-1:0] ra);
        if (ra[AW-1:13] == '0)               return ra + pfx_m;
        else if (ra[AW-1:13] == pfx_m[AW-1:13]) return ra - pfx_m;
        else                                 return ra;
    endfunction

    task automatic access(input logic [AW-1:0] ra, input bit rd, input bit wr,
                          input string req);
        logic [AW-1:0] a;
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1; acc_real_addr = ra; acc_rd = rd; acc_wr = wr;
        #1;
        a = map_ref(ra);
        chk(abs_addr == a, req, abs_addr, a);
        e.vld   = (rd || wr) && (a <= limit_m) && ((a >> 12) < FRAMES);
        e.frame = a[17:12];
        e.r     = rd;
        e.c     = wr;
        e.req   = req;
        @(posedge clk);
        sbq.push_back(e);
        if (e.vld) model[e.frame] = model[e.frame] | {rd, wr};
        @(negedge clk);
        acc_valid = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
        e.vld = 1'b0;
        @(posedge clk);
        sbq.push_back(e);
    endtask

    task automatic set_prefix(input logic [AW-1:0] v);
        @(negedge clk);
        pfx_we = 1'b1; pfx_wdata = v;
        @(negedge clk);
        pfx_we = 1'b0;
        pfx_m = v & ~32'h1FFF;
    endtask

    task automatic read_key(input int idx, input string req);
        @(negedge clk);
        key_rd_idx = 6'(idx);
        #1;
        chk({key_rd_ref, key_rd_chg} == model[idx], req,
            AW'({key_rd_ref, key_rd_chg}), AW'(model[idx]));
    endtask

    // monitor: pops one expected update per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(upd_valid == e.vld, e.req, AW'(upd_valid), AW'(e.vld));
                if (e.vld) begin
                    chk(upd_frame == e.frame, e.req, AW'(upd_frame), AW'(e.frame));
                    chk({upd_ref, upd_chg} == {e.r, e.c}, e.req,
                        AW'({upd_ref, upd_chg}), AW'({e.r, e.c}));
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < FRAMES; i++) model[i] = 2'b00;
        pfx_m = '0; limit_m = 32'h0003_F000;
        rst_n = 1'b0; pfx_we = 1'b0; pfx_wdata = '0; acc_valid = 1'b0;
        acc_real_addr = '0; acc_rd = 1'b0; acc_wr = 1'b0; key_rd_idx = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(upd_valid == 1'b0, "R7", AW'(upd_valid), '0);
        read_key(0, "R7");
        read_key(5, "R7");
        read_key(63, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;

        // R3: pass-through and zero-prefix identity
        access(32'h0000_5000, 1, 0, "R3");
        access(32'h0000_1234, 1, 0, "R3");

        // R4: unaligned prefix write is masked
        set_prefix(32'h0001_2345);
        access(32'h0000_0000, 0, 1, "R4");
        // R1: low window goes to prefix area
        access(32'h0000_1ABC, 1, 0, "R1");
        // R2: prefix window goes to page zero
        access(32'h0001_3FFF, 1, 1, "R2");
        access(32'h0001_2000, 1, 0, "R2");
        // R3: just outside both windows
        access(32'h0000_2000, 1, 0, "R3");
        access(32'h0001_4000, 1, 0, "R3");
        access(32'h0001_1FFF, 0, 1, "R3");
        // R5: limit boundary
        access(32'h0003_F000, 1, 0, "R5");
        access(32'h0003_F004, 0, 1, "R5");
        access(32'h0004_0000, 1, 0, "R5");
        // R6: no permission flags
        access(32'h0000_8000, 0, 0, "R6");
        // R7: bits accumulate and stay set
        access(32'h0000_1ABC, 0, 1, "R7");
        read_key(19, "R7");
        access(32'h0000_1ABC, 1, 0, "R7");
        read_key(19, "R7");
        // R8: read port
        read_key(18, "R8");
        read_key(1, "R8");
        read_key(63, "R8");
        read_key(2, "R8");
        read_key(0, "R8");

        // R2 / R5: wrapped prefix at the top of the address space
        limit_m = 32'hFFFF_FFFF;
        set_prefix(32'hFFFF_E000);
        access(32'hFFFF_F000, 1, 0, "R2");
        access(32'h0000_1000, 0, 1, "R5");
        read_key(1, "R8");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R6", AW'(sbq.size()), '0);
        finish_run();
    end

endmodule